// File: doc/BRIEF.md
# Configurable Pseudo-Random Noise Generator

This block makes the one-bit noise voice of a sound chip. Its source is a linear-feedback shift register with a selectable length of 17, 15, 11 or 9 bits. A separate 7-bit register can replace it. The register advances on a fixed low-rate tick of about 31 kHz, or on the rising edge of one of three tone channel levels. Both registers advance on every step, so switching between them needs no restart.

The selected raw bit then passes through three optional stages in a fixed order:
- a sample-and-hold low-pass stage, clocked by tone 2;
- a high-pass gate, controlled by tone 1;
- a ring modulator, driven by tone 0.

One 8-bit control register sets all of the options. It is written through a single-cycle write strobe. Tone generation and amplitude scaling sit outside this block.

Top module: `pn_noise_gen`

## Requirements
- R1: After reset, the control register is 0x00 and both shift registers hold the seed value 1. The low-pass hold register, the stored previous tone levels and `noise_o` are all 0.
- R2: When `cfg_we` is high at a rising clock edge, the control register loads `cfg_wdata`, and the new value takes effect from the next cycle. While `cfg_we` is low, changes on `cfg_wdata` have no effect on `noise_o`.
- R3: Control bits 1:0 pick the step source.
  - 00 steps on every cycle in which `tick_31k` is high.
  - 01, 10 and 11 step once per rising edge of tone 0, 1 and 2.
  - A rising edge is a level of 1 where the previous cycle's level was 0. The stored previous levels reset to 0.
- R4: Control bits 3:2 pick the long register length and feedback taps: 00 gives 17 bits with taps (17,14), 01 gives 15 with (15,14), 10 gives 11 with (11,9), and 11 gives 9 with (9,5).
  - On a step, the active bits shift up by one. Bit 0 takes the XOR of the two tap bits, counted from 1, and bits above the length are cleared.
  - The long register's raw output is its top active bit.
- R5: Control bit 4 set selects the 7-bit register, with taps (7,6), as the raw source, using its bit 6. The 7-bit register only changes on a step and never holds zero.
- R6: If the active bits of the long register are all zero when a step occurs, the register loads 1 instead, so a length change cannot lock it up.
- R7: The low-pass stage samples the raw bit on every rising edge of tone 2. When control bit 6 is set, the held value replaces the raw bit.
- R8: When control bit 5 is set, the high-pass stage forces its output to 0 while tone 1 is low.
- R9: When control bit 7 is set, the output is the high-pass result XOR tone 0.
- R10: The stages are applied in the order low-pass, then high-pass, then ring modulator. The output follows the tone levels within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_31k | input | 1 | One-cycle step enable at the low fixed rate |
| tone_lvl | input | 3 | Current levels of tone channels 0..2 |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| noise_o | output | 1 | Processed noise bit |

## Verification
The bench sweeps all 256 control values back to back without resets, so every length change lands on a register state left by the previous configuration. A design lacking the lockup guard would then freeze at zero. A design with a wrong tap pair would drift from the model within a few steps. Random tone activity alongside a step source taken from a tone catches level-triggered instead of edge-triggered stepping, which would step on every high cycle. It also catches a low-pass hold that samples on the wrong tone or edge. Cycles where the tone, the sample-and-hold and a control write all coincide expose a wrong stage order or an off-by-one in when a write takes effect.

// File: rtl/pnoise_pkg.sv
package pnoise_pkg;
  localparam int LONG_W  = 17;
  localparam int SHORT_W = 7;
  localparam int SHORT_TAP = 6;
  localparam int CTL_W   = 8;

  function automatic int long_len(input logic [1:0] len_sel);
    case (len_sel)
      2'd0:    return 17;
      2'd1:    return 15;
      2'd2:    return 11;
      default: return 9;
    endcase
  endfunction

  function automatic int long_tap(input logic [1:0] len_sel);
    case (len_sel)
      2'd0:    return 14;
      2'd1:    return 14;
      2'd2:    return 9;
      default: return 5;
    endcase
  endfunction

  function automatic logic [LONG_W-1:0] long_mask(input logic [1:0] len_sel);
    return (LONG_W'(1) << long_len(len_sel)) - LONG_W'(1);
  endfunction

  function automatic logic [LONG_W-1:0] long_next(input logic [LONG_W-1:0] st,
                                                   input logic [1:0] len_sel);
    logic [LONG_W-1:0] m;
    logic fb;
    m = st & long_mask(len_sel);
    if (m == '0) return LONG_W'(1);
    fb = m[long_len(len_sel)-1] ^ m[long_tap(len_sel)-1];
    return ((m << 1) | LONG_W'(fb)) & long_mask(len_sel);
  endfunction

  function automatic logic long_out(input logic [LONG_W-1:0] st,
                                    input logic [1:0] len_sel);
    return st[long_len(len_sel)-1];
  endfunction

  function automatic logic [SHORT_W-1:0] short_next(input logic [SHORT_W-1:0] st);
    logic fb;
    if (st == '0) return SHORT_W'(1);
    fb = st[SHORT_W-1] ^ st[SHORT_TAP-1];
    return {st[SHORT_W-2:0], fb};
  endfunction
endpackage

// File: rtl/pn_step_sel.sv
module pn_step_sel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] tone,
  input  logic [1:0] sel,
  output logic       step,
  output logic [2:0] tone_rise
);
  logic [2:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= tone;
  end

  assign tone_rise = tone & ~prev_q;

  always_comb begin
    case (sel)
      2'd0:    step = tick;
      2'd1:    step = tone_rise[0];
      2'd2:    step = tone_rise[1];
      default: step = tone_rise[2];
    endcase
  end

  assert_step_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ((sel == 2'd0) ? tick : tone[sel - 2'd1]));

  assert_one_step_per_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sel != 2'd0) |=> (!step || sel != $past(sel)));
endmodule

// File: rtl/pn_shift.sv
module pn_shift
  import pnoise_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [1:0] len_sel,
  input  logic       short_sel,
  output logic       raw
);
  logic [LONG_W-1:0]  long_q;
  logic [SHORT_W-1:0] short_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      long_q  <= LONG_W'(1);
      short_q <= SHORT_W'(1);
    end else if (step) begin
      long_q  <= long_next(long_q, len_sel);
      short_q <= short_next(short_q);
    end
  end

  assign raw = short_sel ? short_q[SHORT_W-1] : long_out(long_q, len_sel);

  assert_long_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (long_q != '0));

  assert_short_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(short_q));

  assert_short_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    short_q != '0);
endmodule

// File: rtl/pn_shape.sv
module pn_shape (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw,
  input  logic [2:0] tone,
  input  logic [2:0] tone_rise,
  input  logic       lp_en,
  input  logic       hp_en,
  input  logic       ring_en,
  output logic       noise
);
  logic lp_q;
  logic lp_stage;
  logic hp_stage;

  always_ff @(posedge clk) begin
    if (!rst_n)            lp_q <= 1'b0;
    else if (tone_rise[2]) lp_q <= raw;
  end

  assign lp_stage = lp_en ? lp_q : raw;
  assign hp_stage = hp_en ? (lp_stage & tone[1]) : lp_stage;
  assign noise    = ring_en ? (hp_stage ^ tone[0]) : hp_stage;

  assert_lp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_rise[2] |=> $stable(lp_q));

  assert_hp_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_en && !tone[1]) |-> !hp_stage);

  assert_ring_after_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_en && hp_en && !tone[1]) |-> (noise == tone[0]));
endmodule

// File: rtl/pn_noise_gen.sv
module pn_noise_gen
  import pnoise_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_31k,
  input  logic [2:0]       tone_lvl,
  input  logic             cfg_we,
  input  logic [CTL_W-1:0] cfg_wdata,
  output logic             noise_o
);
  logic [CTL_W-1:0] ctl_q;
  logic             step;
  logic [2:0]       tone_rise;
  logic             raw;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (cfg_we) ctl_q <= cfg_wdata;
  end

  pn_step_sel u_step (
    .clk(clk), .rst_n(rst_n), .tick(tick_31k), .tone(tone_lvl),
    .sel(ctl_q[1:0]), .step(step), .tone_rise(tone_rise)
  );

  pn_shift u_shift (
    .clk(clk), .rst_n(rst_n), .step(step), .len_sel(ctl_q[3:2]),
    .short_sel(ctl_q[4]), .raw(raw)
  );

  pn_shape u_shape (
    .clk(clk), .rst_n(rst_n), .raw(raw), .tone(tone_lvl), .tone_rise(tone_rise),
    .lp_en(ctl_q[6]), .hp_en(ctl_q[5]), .ring_en(ctl_q[7]), .noise(noise_o)
  );

  assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(ctl_q));

  assert_ctl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (ctl_q == $past(cfg_wdata)));
endmodule

// File: tb/tb_pn_noise_gen.sv
`timescale 1ns/1ps
module tb_pn_noise_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_31k;
  logic [2:0] tone_lvl;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic       noise_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [16:0] m_long;
  logic [6:0]  m_short;
  logic [7:0]  m_ctl;
  logic [2:0]  m_prev;
  logic        m_lp;

  always #2 clk = ~clk;

  pn_noise_gen dut (
    .clk(clk), .rst_n(rst_n), .tick_31k(tick_31k), .tone_lvl(tone_lvl),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .noise_o(noise_o)
  );

  function automatic int m_len(input logic [1:0] s);
    int l;
    l = 17 - 2 * int'(s);
    if (s == 2'd2) l = 11;
    if (s == 2'd3) l = 9;
    return l;
  endfunction

  function automatic int m_tap(input logic [1:0] s);
    int t [4];
    t = '{14, 14, 9, 5};
    return t[s];
  endfunction

  function automatic logic [16:0] m_step_long(input logic [16:0] s, input int len, input int tap);
    logic [16:0] r;
    bit any;
    any = 0;
    for (int i = 0; i < len; i++) if (s[i]) any = 1;
    if (!any) return 17'd1;
    r = '0;
    for (int i = len - 1; i >= 1; i--) r[i] = s[i-1];
    r[0] = s[len-1] ^ s[tap-1];
    return r;
  endfunction

  function automatic logic m_raw();
    if (m_ctl[4]) return m_short[6];
    return m_long[m_len(m_ctl[3:2]) - 1];
  endfunction

  function automatic logic m_out(input logic [2:0] t);
    logic v;
    v = m_ctl[6] ? m_lp : m_raw();
    if (m_ctl[5] && !t[1]) v = 1'b0;
    if (m_ctl[7]) v = v ^ t[0];
    return v;
  endfunction

  function automatic string tag_of(input logic [7:0] c);
    if (c[7] && (c[5] || c[6])) return "R10";
    if (c[7]) return "R9";
    if (c[5]) return "R8";
    if (c[6]) return "R7";
    if (c[4]) return "R5";
    if (c[1:0] != 2'd0) return "R3";
    return "R4";
  endfunction

  // model update at each rising edge, from values held stable since the last falling edge
  task automatic model_edge();
    logic [2:0] rise;
    logic st;
    logic old_raw;
    if (!rst_n) begin
      m_long = 17'd1; m_short = 7'd1; m_ctl = 8'd0; m_prev = 3'd0; m_lp = 1'b0;
      return;
    end
    rise = tone_lvl & ~m_prev;
    st = (m_ctl[1:0] == 2'd0) ? tick_31k : rise[m_ctl[1:0] - 2'd1];
    old_raw = m_raw();
    if (st) begin
      m_long  = m_step_long(m_long, m_len(m_ctl[3:2]), m_tap(m_ctl[3:2]));
      m_short = {m_short[5:0], m_short[6] ^ m_short[5]};
    end
    if (rise[2]) m_lp = old_raw;
    m_prev = tone_lvl;
    if (cfg_we) m_ctl = cfg_wdata;
  endtask

  task automatic check(input string tag);
    logic e;
    e = m_out(tone_lvl);
    n_vec++;
    if (noise_o !== e) begin
      n_bad++;
      $display("FAIL %s ctl=%02h tone=%b actual=%b expected=%b", tag, m_ctl, tone_lvl, noise_o, e);
    end
  endtask

  // one clock: model edge, then new inputs at the falling edge, then a check
  task automatic cycle(input logic tk, input logic [2:0] tn, input logic we,
                       input logic [7:0] wd, input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    tick_31k = tk; tone_lvl = tn; cfg_we = we; cfg_wdata = wd;
    #1;
    check(tag);
  endtask

  initial begin
    logic [2:0] tn;
    rst_n = 1'b0; tick_31k = 0; tone_lvl = 0; cfg_we = 0; cfg_wdata = 0;
    m_long = 17'd1; m_short = 7'd1; m_ctl = 0; m_prev = 0; m_lp = 0;
    repeat (3) @(posedge clk);
    model_edge();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1");
    n_vec++;
    if (noise_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset output actual=%b expected=0", noise_o);
    end

    // data changing without the write strobe must leave behaviour unchanged (R2)
    tn = 3'b000;
    for (int i = 0; i < 40; i++) begin
      tn = tn ^ 3'($urandom_range(0, 7) & 3'b001);
      cycle(1'b1, tn, 1'b0, 8'($urandom), "R2");
    end

    // sweep every control value, no resets in between
    for (int c = 0; c < 256; c++) begin
      cycle(1'b0, tn, 1'b1, 8'(c), tag_of(8'(c)));
      for (int k = 0; k < 150; k++) begin
        for (int b = 0; b < 3; b++)
          if ($urandom_range(0, 3) == 0) tn[b] = ~tn[b];
        cycle(($urandom_range(0, 3) == 0), tn, 1'b0, 8'($urandom), tag_of(8'(c)));
      end
    end

    // length changes against arbitrary states, fast stepping, exercising the lockup guard (R6)
    for (int r = 0; r < 40; r++) begin
      cycle(1'b1, tn, 1'b1, {4'b0000, 2'($urandom), 2'b00}, "R6");
      for (int k = 0; k < 60; k++) cycle(1'b1, tn, 1'b0, 8'h00, "R6");
    end

    // long run on the 9-bit length well past its period
    cycle(1'b1, tn, 1'b1, 8'h0C, "R4");
    for (int k = 0; k < 1100; k++) cycle(1'b1, tn, 1'b0, 8'h00, "R4");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule